// File: doc/BRIEF.md
# MDIO Management Command Engine

This block is a management-bus master for Clause 22 PHY register access. It has one 32-bit command register. Software loads the opcode, the PHY address, the register address and the write data into that register. It then sets the start/busy bit with a second write. The engine sends one complete frame on MDC/MDIO, clears the busy bit by itself when the frame ends, and polling that bit shows software when the command has finished.

For a read, the engine releases MDIO from the turnaround onward and samples the PHY on each rising MDC edge. When the frame ends, the 16 received bits are placed in the low half of the command register. A read-fail flag records whether the PHY answered in the turnaround. MDC is divided down from the system clock by a parameter. MDIO changes only on falling MDC edges, so the PHY sees a stable level when it samples on the rising edge.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the command register reads 32'h0000_0000, MDC is low and the MDIO output enable is low.
- R2: The command word is laid out as follows: bit 29 is start/busy, bit 28 is read-fail, bits 27:26 are the opcode, bits 25:21 the PHY address, bits 20:16 the register address and bits 15:0 the data. A write while idle stores bits 27:0. Bit 28 cannot be written.
- R3: A write while idle with bit 29 set starts a transaction, and bit 29 reads 1 from the next clock onward.
- R4: Opcode 2'b10 is a read. Every other opcode (2'b01 is the write) is sent as a write frame: 32 ones, then 01, the opcode, the PHY address, the register address, turnaround 10 and the 16 data bits, each field MSB first, with output enable high throughout.
- R5: MDC has a period of 2*MDC_HALF_DIV system clocks while busy. MDIO changes only on falling MDC edges.
- R6: A read drives the first 46 frame bits (the turnaround of a read frame is 11) and holds output enable low for the last 18 bits. The 16 bits sampled on rising MDC edges during the data phase, MSB first, end up in bits 15:0.
- R7: Read-fail (bit 28) is set at the end of a read if MDIO was high at the rising MDC edge of the second turnaround bit. Otherwise it is cleared.
- R8: Starting a new command clears read-fail.
- R9: The busy bit clears by itself 64 MDC periods (128*MDC_HALF_DIV clocks) after the start.
- R10: A write to the register while busy changes nothing and does not start a second frame.
- R11: While idle, MDC stays low and MDIO is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Command register write strobe |
| reg_wr_data | input | 32 | Command register write value |
| reg_rd_data | output | 32 | Command register contents |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The bench builds the engine with MDC_HALF_DIV set to 2. A whole frame therefore lasts only 256 clocks, which leaves room for dozens of random reads and writes. With a divisor this short, the exact cycle count to completion and the edge spacing of MDC can be checked against the 2*MDC_HALF_DIV period. A PHY model in the bench answers reads with random data and sometimes leaves the second turnaround bit high, so that the fail flag is driven to both values. It also injects a write partway through a frame, which checks that a busy write is ignored.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;

    localparam int DATA_W       = 16;
    localparam int ADDR_W       = 5;
    localparam int PREAMBLE_LEN = 32;
    localparam int HDR_LEN      = 2 + 2 + ADDR_W + ADDR_W;     // start, op, phy, reg
    localparam int FRAME_LEN    = PREAMBLE_LEN + HDR_LEN + 2 + DATA_W;
    localparam int IDX_W        = $clog2(FRAME_LEN);
    localparam int TA_FIRST     = PREAMBLE_LEN + HDR_LEN;
    localparam int TA_LAST      = TA_FIRST + 1;
    localparam int DATA_FIRST   = TA_LAST + 1;

    localparam int BIT_BUSY     = 29;
    localparam int BIT_FAIL     = 28;
    localparam int CMD_W        = 2 + 2 * ADDR_W + DATA_W;     // bits 27:0

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_RSVD  = 2'b11
    } mdio_op_e;

    // Field order matches the register layout so bits 27:0 cast directly.
    typedef struct packed {
        mdio_op_e            op;
        logic [ADDR_W-1:0]   phy;
        logic [ADDR_W-1:0]   regad;
        logic [DATA_W-1:0]   data;
    } mdio_cmd_t;

    function automatic logic op_is_read(input mdio_op_e op);
        return op == OP_READ;
    endfunction

    function automatic logic [FRAME_LEN-1:0] build_frame(input mdio_cmd_t c);
        logic [1:0] ta;
        ta = op_is_read(c.op) ? 2'b11 : 2'b10;
        return {{PREAMBLE_LEN{1'b1}}, 2'b01, c.op, c.phy, c.regad, ta, c.data};
    endfunction

    function automatic logic [31:0] pack_word(input logic busy, input logic fail,
                                              input mdio_cmd_t c);
        return {2'b00, busy, fail, c};
    endfunction

endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
    parameter int HALF_DIV = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    logic wrap;

    generate
        if (HALF_DIV <= 1) begin : g_fast
            always_ff @(posedge clk) begin
                if (rst || !run) mdc <= 1'b0;
                else             mdc <= ~mdc;
            end
            assign wrap = run;
        end else begin : g_count
            localparam int CW = $clog2(HALF_DIV);
            localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    cnt <= '0;
                    mdc <= 1'b0;
                end else if (cnt == LAST) begin
                    cnt <= '0;
                    mdc <= ~mdc;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            assign wrap = run && (cnt == LAST);
        end
    endgenerate

    assign rise_stb = wrap && !mdc;
    assign fall_stb = wrap &&  mdc;
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
    import mdio_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  mdio_cmd_t         cmd,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rd_value,
    output logic              rd_fail
);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] IDX_TA0   = IDX_W'(TA_FIRST);
    localparam logic [IDX_W-1:0] IDX_TA1   = IDX_W'(TA_LAST);
    localparam logic [IDX_W-1:0] IDX_DATA0 = IDX_W'(DATA_FIRST);

    logic [IDX_W-1:0]     idx;
    logic [FRAME_LEN-1:0] frame;
    logic                 is_rd;
    logic                 released;

    assign frame    = build_frame(cmd);
    assign is_rd    = op_is_read(cmd.op);
    assign released = is_rd && (idx >= IDX_TA0);
    assign done     = fall_stb && (idx == IDX_LAST);
    assign mdio_o   = run ? frame[IDX_LAST - idx] : 1'b1;
    assign mdio_oe  = run && !released;

    // Bit position advances on falling MDC, so output changes while MDC is low.
    always_ff @(posedge clk) begin
        if (rst || !run)                        idx <= '0;
        else if (fall_stb && idx != IDX_LAST)   idx <= idx + 1'b1;
    end

    // Sampling happens on rising MDC.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_value <= '0;
            rd_fail  <= 1'b0;
        end else if (run && rise_stb && is_rd) begin
            if (idx == IDX_TA1)   rd_fail  <= mdio_i;
            if (idx >= IDX_DATA0) rd_value <= {rd_value[DATA_W-2:0], mdio_i};
        end
    end
endmodule

// File: rtl/mdio_cmd_reg.sv
module mdio_cmd_reg
    import mdio_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              done,
    input  logic [DATA_W-1:0] rd_value,
    input  logic              rd_fail,
    output mdio_cmd_t         cmd,
    output logic              busy,
    output logic [31:0]       word
);
    logic fail;
    logic accept;

    assign accept = wr_en && !busy;
    assign word   = pack_word(busy, fail, cmd);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd  <= '0;
            busy <= 1'b0;
            fail <= 1'b0;
        end else if (busy) begin
            if (done) begin
                busy <= 1'b0;
                if (op_is_read(cmd.op)) begin
                    cmd.data <= rd_value;
                    fail     <= rd_fail;
                end
            end
        end else if (accept) begin
            cmd <= mdio_cmd_t'(wr_data[CMD_W-1:0]);
            if (wr_data[BIT_BUSY]) begin
                busy <= 1'b1;
                fail <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
    import mdio_cmd_pkg::*;
#(
    parameter int MDC_HALF_DIV = 40
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr_en,
    input  logic [31:0] reg_wr_data,
    output logic [31:0] reg_rd_data,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    mdio_cmd_t         cmd;
    logic              busy;
    logic              rise_stb;
    logic              fall_stb;
    logic              frame_done;
    logic [DATA_W-1:0] rd_value;
    logic              rd_fail;

    mdio_cmd_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr_en),
        .wr_data  (reg_wr_data),
        .done     (frame_done),
        .rd_value (rd_value),
        .rd_fail  (rd_fail),
        .cmd      (cmd),
        .busy     (busy),
        .word     (reg_rd_data)
    );

    mdc_divider #(.HALF_DIV(MDC_HALF_DIV)) u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .cmd      (cmd),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (frame_done),
        .rd_value (rd_value),
        .rd_fail  (rd_fail)
    );
endmodule

// File: rtl/mdio_cmd_engine_chk.sv
module mdio_cmd_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr_en,
    input logic [31:0] reg_rd_data,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        done
);
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !reg_rd_data[29] |-> (!mdc && !mdio_oe));

    a_r5_stable_at_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(mdc) |-> $stable(mdio_o));

    a_r10_busy_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_data[29] && reg_wr_en && !done) |=> $stable(reg_rd_data[27:0]));

    a_r8_fail_cleared_on_start: assert property (@(posedge clk) disable iff (rst)
        $rose(reg_rd_data[29]) |-> !reg_rd_data[28]);

    a_r4_write_always_driven: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_data[29] && reg_rd_data[27:26] != 2'b10) |-> mdio_oe);

    a_r9_done_clears_busy: assert property (@(posedge clk) disable iff (rst)
        done |=> !reg_rd_data[29]);
endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_en   (reg_wr_en),
    .reg_rd_data (reg_rd_data),
    .mdc         (mdc),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe),
    .done        (frame_done)
);

// File: tb/mdio_cmd_engine_tb.sv
`timescale 1ns/1ps
module mdio_cmd_engine_tb;
    localparam int H = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    mdio_cmd_engine #(.MDC_HALF_DIV(H)) u_dut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model: captures on rising MDC, answers on falling MDC.
    logic [63:0] cap, oecap, resp;
    int n = 0;
    int cyc = 0, last_rise = 0, per_min = 0, per_max = 0;

    always @(negedge clk) cyc = cyc + 1;

    always @(posedge mdc) begin
        if (n < 64) begin
            cap[63-n]   = mdio_o;
            oecap[63-n] = mdio_oe;
        end
        if (n > 0) begin
            if (cyc - last_rise < per_min) per_min = cyc - last_rise;
            if (cyc - last_rise > per_max) per_max = cyc - last_rise;
        end
        last_rise = cyc;
        n = n + 1;
    end

    always @(negedge mdc) begin
        if (n < 64) mdio_i = resp[63-n];
        else        mdio_i = 1'b1;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [31:0] d);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en   = 1'b0;
    endtask

    function automatic logic [27:0] fields(input logic [1:0] op, input logic [4:0] phy,
                                           input logic [4:0] rg, input logic [15:0] d);
        return {op, phy, rg, d};
    endfunction

    function automatic logic [63:0] exp_frame(input logic [1:0] op, input logic [4:0] phy,
                                              input logic [4:0] rg, input logic [15:0] d);
        logic [1:0] ta;
        ta = (op == 2'b10) ? 2'b11 : 2'b10;
        return {32'hFFFF_FFFF, 2'b01, op, phy, rg, ta, d};
    endfunction

    task automatic run_txn(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] d, input logic [15:0] phy_val,
                           input bit bad_ta, input bit intrude);
        int cycles;
        bit is_rd;
        logic [63:0] ef;
        is_rd = (op == 2'b10);
        resp  = {46'h3FFF_FFFF_FFFF, 1'b1, bad_ta, phy_val};
        n = 0; per_min = 1000; per_max = 0;
        mdio_i = 1'b1;
        reg_write({4'b0000, fields(op, phy, rg, d)});
        reg_write({4'b0010, fields(op, phy, rg, d)});
        check(reg_rd_data[29] == 1'b1, "R3 busy after start", 64'(reg_rd_data[29]), 64'd1);
        check(reg_rd_data[28] == 1'b0, "R8 fail cleared on start", 64'(reg_rd_data[28]), 64'd0);
        cycles = 0;
        while (reg_rd_data[29] && cycles < 10000) begin
            if (intrude && cycles == 20) begin
                reg_wr_en   = 1'b1;
                reg_wr_data = ~{4'b1101, fields(op, phy, rg, d)};
            end
            @(posedge clk); @(negedge clk);
            reg_wr_en = 1'b0;
            cycles++;
            if (intrude && cycles == 21)
                check(reg_rd_data[27:0] == fields(op, phy, rg, d), "R10 fields held",
                      64'(reg_rd_data[27:0]), 64'(fields(op, phy, rg, d)));
        end
        check(cycles == 128 * H, "R9 completion time", 64'(cycles), 64'(128 * H));
        check(n == 64, "R9 MDC periods", 64'(n), 64'd64);
        check(per_min == 2 * H && per_max == 2 * H, "R5 MDC period",
              {32'(per_min), 32'(per_max)}, {32'(2 * H), 32'(2 * H)});
        ef = exp_frame(op, phy, rg, d);
        if (!is_rd) begin
            check(cap == ef, "R4 write frame", cap, ef);
            check(oecap == '1, "R4 write output enable", oecap, '1);
            check(reg_rd_data[15:0] == d, "R4 write data kept", 64'(reg_rd_data[15:0]), 64'(d));
        end else begin
            check(cap[63:18] == ef[63:18], "R6 read header", 64'(cap[63:18]), 64'(ef[63:18]));
            check(oecap == {{46{1'b1}}, 18'h0}, "R6 read release", oecap, {{46{1'b1}}, 18'h0});
            check(reg_rd_data[15:0] == phy_val, "R6 read data", 64'(reg_rd_data[15:0]), 64'(phy_val));
            check(reg_rd_data[28] == bad_ta, "R7 read fail flag", 64'(reg_rd_data[28]), 64'(bad_ta));
        end
        check(reg_rd_data[27:16] == {op, phy, rg}, "R2 fields after completion",
              64'(reg_rd_data[27:16]), 64'({op, phy, rg}));
        if (intrude) begin
            repeat (10) @(negedge clk);
            check(reg_rd_data[29] == 1'b0 && !mdc, "R10 no second frame",
                  64'({reg_rd_data[29], mdc}), 64'd0);
        end
    endtask

    initial begin
        #1_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(reg_rd_data == 32'h0, "R1 reset word", 64'(reg_rd_data), 64'h0);
        check(!mdc && !mdio_oe, "R1 reset pins", 64'({mdc, mdio_oe}), 64'h0);

        // R2: bit 28 and 31:30 not writable, no start
        reg_write(32'hDFFF_FFFF);
        check(reg_rd_data == 32'h0FFF_FFFF, "R2 field storage", 64'(reg_rd_data), 64'h0FFF_FFFF);
        repeat (8) @(negedge clk);
        check(!mdc && !mdio_oe, "R11 idle pins", 64'({mdc, mdio_oe}), 64'h0);

        // Directed corners
        run_txn(2'b01, 5'h1F, 5'h00, 16'hA5C3, 16'h0000, 1'b0, 1'b0);
        run_txn(2'b10, 5'h01, 5'h1F, 16'h0000, 16'hFFFF, 1'b0, 1'b0);
        run_txn(2'b10, 5'h00, 5'h02, 16'h1234, 16'h8001, 1'b1, 1'b0);
        // R2: read-fail is read-only; idle write without start keeps it
        reg_write({4'b0000, fields(2'b10, 5'h00, 5'h02, 16'h8001)});
        check(reg_rd_data[28] == 1'b1, "R2 fail bit read-only", 64'(reg_rd_data[28]), 64'd1);
        run_txn(2'b01, 5'h0A, 5'h05, 16'h0F0F, 16'h0000, 1'b0, 1'b1);
        run_txn(2'b10, 5'h11, 5'h07, 16'h0000, 16'h5A5A, 1'b0, 1'b1);

        // Random
        for (int i = 0; i < 24; i++) begin
            logic [1:0] op;
            op = ($urandom % 3 == 0) ? 2'($urandom) : (($urandom % 2) ? 2'b10 : 2'b01);
            run_txn(op, 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom),
                    ($urandom % 4) == 0, 1'b0);
            repeat ($urandom % 5) @(negedge clk);
            check(!mdc && !mdio_oe, "R11 idle between commands", 64'({mdc, mdio_oe}), 64'h0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule